// File: doc/BRIEF.md
# Start-up Noise Reference Capture

This block learns a noise reference spectrum once, at the start of operation, and then plays it back next to the live spectrum so that a later stage can subtract it. Its input is a stream of spectral values (magnitude or phase, one word per bin) with a valid strobe and the bin index. The first few valid values after reset are taken to be noise only and are stored in a small single-port memory. The memory writes only for those first values. After that it only reads, and the stored reference never changes until the next reset.

One instance handles one channel: a magnitude path and a phase path each use their own copy. Every output word leaves one cycle after it arrived, together with the stored noise value for its bin position and a flag that says whether the reference is complete. While that flag is low, the downstream subtractor must pass the signal through unchanged. The write controller is a saturating sample counter with a less-than comparator. The memory is addressed by the bin index modulo its depth, so bins of later frames read back the reference stored for the matching position.

Top module: `nref_capture`

## Requirements
- R1: While reset is held low (synchronous, active low) and in the first cycle after it, `out_valid` and `noise_ready` are 0.
- R2: Each accepted input (`in_valid`=1) appears on `out_sig` with `out_valid`=1 exactly one clock later. A cycle with `in_valid`=0 gives `out_valid`=0 one clock later.
- R3: For each of the first `CAP_SAMPLES` (default 5) valid inputs after reset, the memory is written, and `out_noise` shows that same input value one clock later (write-first read).
- R4: Only valid inputs advance the capture count. Data and bin values presented while `in_valid`=0 are neither stored nor counted.
- R5: The capture count saturates at `CAP_SAMPLES`. Once `noise_ready` is 1 it stays 1 until reset, however many inputs follow.
- R6: After capture, each output carries on `out_noise` the value that was captured at address `in_bin % MEM_DEPTH` (default depth 5).
- R7: Inputs after capture never change the stored reference. The same address reads back the same captured value in every later frame.
- R8: `noise_ready` is 0 on the outputs of the first `CAP_SAMPLES`-1 captured samples. It becomes 1 together with the output of the last captured sample.
- R9: A reset asserted mid-stream clears the count and `noise_ready`, and a fresh capture follows. It may start at any bin index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_sig | input | DATA_W | Spectral value (magnitude or phase) |
| in_bin | input | BIN_W | Bin index within the frame |
| out_valid | output | 1 | Output word strobe, one cycle after the input |
| out_sig | output | DATA_W | Delayed input value |
| out_noise | output | DATA_W | Noise reference for this bin |
| noise_ready | output | 1 | Reference capture complete |

## Verification
The hardest case to reach is the boundary of the capture window when it is interleaved with idle cycles. The stimulus places junk-valued cycles with `in_valid` low between the captured samples, so that a counter advancing on invalid cycles would lock in the wrong words. The flag must rise on exactly the last captured output. A second capture after a mid-stream reset starts at bin 7, so the wrapped addresses fill out of order. Full frames of readback afterwards show whether each modulo address still holds its own captured value.

// File: rtl/nref_pkg.sv
// Package: shared defaults for the noise reference capture block.
// Assumes: every module of the block takes its widths from these values.
package nref_pkg;
    localparam int unsigned DEF_DATA_W      = 16;
    localparam int unsigned DEF_BIN_W       = 8;
    localparam int unsigned DEF_CAP_SAMPLES = 5;
    localparam int unsigned DEF_MEM_DEPTH   = 5;
endpackage

// File: rtl/nref_wr_ctrl.sv
// Write controller: counts valid samples after reset and keeps the memory
// write enable high while the count is below CAP_SAMPLES.
// Assumes: rst_n is synchronous and active low; the count never wraps.
module nref_wr_ctrl #(
    parameter int unsigned CAP_SAMPLES = nref_pkg::DEF_CAP_SAMPLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic wr_en,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(CAP_SAMPLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CAP_SAMPLES);

    logic [CNT_W-1:0] cnt;

    // Comparator: write while fewer than CAP_SAMPLES samples are stored.
    assign wr_en = rst_n && in_valid && (cnt < CNT_MAX);
    assign done  = (cnt == CNT_MAX);

    // Saturating counter of captured samples.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_en) cnt <= cnt + 1'b1;
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_idle_no_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt));
endmodule

// File: rtl/nref_spram.sv
// Single-port RAM with write-first read: a write also returns the new word
// on the registered read port. The read port holds while the port is idle.
// Assumes: en qualifies both read and write; no reset on the array.
module nref_spram #(
    parameter int unsigned DATA_W = nref_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = nref_pkg::DEF_MEM_DEPTH,
    localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Port access: write-first on a write, plain read otherwise.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
                rdata     <= wdata;
            end else begin
                rdata     <= mem[addr];
            end
        end
    end

    p_write_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> rdata == $past(wdata));
    p_we_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> en);
endmodule

// File: rtl/nref_capture.sv
// Top: captures a noise-only reference from the first CAP_SAMPLES valid
// spectral words after reset, then replays it by bin index modulo MEM_DEPTH.
// The signal is delayed one cycle to line up with the registered RAM read.
// Assumes: the earliest input after reset is noise only; one channel.
module nref_capture #(
    parameter int unsigned DATA_W      = nref_pkg::DEF_DATA_W,
    parameter int unsigned BIN_W       = nref_pkg::DEF_BIN_W,
    parameter int unsigned CAP_SAMPLES = nref_pkg::DEF_CAP_SAMPLES,
    parameter int unsigned MEM_DEPTH   = nref_pkg::DEF_MEM_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sig,
    input  logic [BIN_W-1:0]  in_bin,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sig,
    output logic [DATA_W-1:0] out_noise,
    output logic              noise_ready
);
    localparam int unsigned ADDR_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
    localparam logic [BIN_W-1:0] DEPTH_B = BIN_W'(MEM_DEPTH);

    logic              wr_en;
    logic              cap_done;
    logic [ADDR_W-1:0] ram_addr;

    // Address: bin position folded into the stored depth.
    assign ram_addr = ADDR_W'(in_bin % DEPTH_B);

    nref_wr_ctrl #(.CAP_SAMPLES(CAP_SAMPLES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .wr_en    (wr_en),
        .done     (cap_done)
    );

    nref_spram #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .we    (wr_en),
        .addr  (ram_addr),
        .wdata (in_sig),
        .rdata (out_noise)
    );

    // Strobe delay matching the one-cycle RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Data delay matching the one-cycle RAM read.
    always_ff @(posedge clk) begin
        if (in_valid) out_sig <= in_sig;
    end

    assign noise_ready = cap_done;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_capture_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (out_noise == out_sig));
    p_ready_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_ready) |-> $past(wr_en));
    p_no_write_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        noise_ready |-> !wr_en);
endmodule

// File: tb/sim_nref_capture.sv
module sim_nref_capture;
    localparam int DW = 16;
    localparam int BW = 8;
    localparam int CAP = 5;
    localparam int DEP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sig = '0;
    logic [BW-1:0] in_bin = '0;
    logic          out_valid;
    logic [DW-1:0] out_sig;
    logic [DW-1:0] out_noise;
    logic          noise_ready;

    always #5 clk = ~clk;

    nref_capture u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sig(in_sig),
        .in_bin(in_bin), .out_valid(out_valid), .out_sig(out_sig),
        .out_noise(out_noise), .noise_ready(noise_ready)
    );

    typedef struct {
        logic [DW-1:0] sig;
        logic [DW-1:0] noise;
        logic          rdy;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_chk = 0;
    int            n_bad = 0;
    int            m_cnt = 0;
    logic [DW-1:0] m_ref [DEP];
    bit            done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one input per call, expected item pushed for valid words.
    task automatic drive(input bit v, input logic [DW-1:0] s, input int b);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        in_sig   = s;
        in_bin   = BW'(b);
        if (v) begin
            e.sig = s;
            if (m_cnt < CAP) begin
                m_ref[b % DEP] = s;
                m_cnt++;
                e.noise = s;
                e.tag   = (m_cnt == CAP) ? "R8" : "R3";
            end else begin
                e.noise = m_ref[b % DEP];
                e.tag   = "R6";
            end
            e.rdy = (m_cnt == CAP);
            sb.push_back(e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        m_cnt = 0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(noise_ready == 1'b0, "R1", "noise_ready in reset", noise_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(noise_ready == 1'b0, "R1", "noise_ready after reset", noise_ready, 0);
    endtask

    // Monitor: pops and compares as results appear.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(out_sig == e.sig, "R2", "out_sig", out_sig, e.sig);
                chk(out_noise == e.noise, e.tag, "out_noise", out_noise, e.noise);
                chk(noise_ready == e.rdy, (e.tag == "R6") ? "R5" : "R8",
                    "noise_ready", noise_ready, e.rdy);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        do_reset();
        // First capture, idle cycles with junk between captured words (R4).
        for (int b = 0; b < 256; b++) begin
            drive(1'b1, DW'(16'h1000 + b * 3), b);
            if (b < 6) drive(1'b0, 16'hDEAD, (b + 2) % 256);
        end
        // Second frame: readback at every modulo address (R6, R7).
        for (int b = 0; b < 256; b++) drive(1'b1, DW'(16'h7000 ^ (b * 77)), b);
        drive(1'b0, 16'h0, 0);
        drive(1'b0, 16'h0, 0);
        chk(sb.size() == 0, "R2", "queue drained", sb.size(), 0);
        chk(noise_ready == 1'b1, "R5", "ready holds", noise_ready, 1);
        // Mid-stream reset, then a capture that begins at bin 7 (R9).
        drive(1'b1, 16'h4444, 9);
        do_reset();
        sb.delete();
        chk(noise_ready == 1'b0, "R9", "ready cleared", noise_ready, 0);
        for (int b = 7; b < 256; b++) drive(1'b1, DW'(16'h2000 + b * 11), b);
        for (int b = 0; b < 256; b++) drive(1'b1, DW'(16'hA5A5 - b), b);
        drive(1'b0, 16'h0, 0);
        drive(1'b0, 16'h0, 0);
        chk(sb.size() == 0, "R9", "queue drained", sb.size(), 0);
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) chk(0, "R2", "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule